// File: doc/BRIEF.md
# Four-Way Set-Associative Read and Hit Path

This block is the lookup half of a four-way set-associative cache that holds 32-bit words in 256 sets. A 32-bit request address is split into a 22-bit tag, an 8-bit set index and a 2-bit byte offset. The offset plays no part in the lookup. The index and tag go to all four way stores at once. Each way store reports whether its entry at that index is valid and holds the same tag, and it supplies the stored word.

The four per-way hit flags are combined into a single cache hit. They are also priority-encoded into a 2-bit select that steers the matching way's word onto the read port. The lookup is combinational from the address to the outputs.

A single write port fills the cache. When the write strobe is high at a rising clock edge, the way named by the way-select input takes the tag and index of the current address, becomes valid, and stores the write word. Miss handling, refill sequencing and replacement choice belong to the surrounding logic.

Top module: `sa4_lookup`

## Requirements
- R1: While reset is low, and after it is released until the first write, every way is invalid, so hit reads 0 for any address.
- R2: The tag is address bits [31:10] and the set index is bits [9:2]. Bits [1:0] have no effect on hit or rd_data.
- R3: When wr_en is 1 at a rising clock edge, the way numbered by wr_way (0 to 3) at the addressed index becomes valid and stores the address tag and wr_data. The other ways and the other indices keep their contents.
- R4: hit is 1 in the same cycle as the address when any valid way at the addressed index holds the addressed tag, and 0 otherwise.
- R5: On a hit, rd_data equals the word stored in the matching way.
- R6: When several ways at one index hold the requested tag, rd_data comes from the lowest-numbered of them.
- R7: On a miss, rd_data is zero.
- R8: When wr_en is 0 at a clock edge, the stored contents do not change, whatever values wr_way and wr_data carry.
- R9: A tag stored at one index does not produce a hit when the same tag is requested at a different index.
- R10: Writing a way again at the same index replaces its tag, so the old tag no longer hits in that way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid bits |
| addr | input | 32 | Request address used for both lookup and write |
| wr_en | input | 1 | Write strobe for the fill port |
| wr_way | input | 2 | Number of the way that takes the write |
| wr_data | input | 32 | Word stored on a write |
| hit | output | 1 | 1 when the addressed tag is present in some way |
| rd_data | output | 32 | Word of the matching way, or zero on a miss |

## Verification
The hardest case to reach from the ports is a set where two or more ways hold the same tag, because correct use of the fill port never creates one. The bench creates it on purpose. It writes a tag that is already held by one way into a higher-numbered way with a different word, and checks that the lower way's word is still returned. It then writes the same tag into way 0 and checks that way 0 now wins. Around this case, the bench fills every set with four distinct tags and looks each one up under all four byte offsets. It also probes absent tags and tags that belong to neighbouring sets.

// File: rtl/sa4_pkg.sv
package sa4_pkg;
   localparam int unsigned SA4_ADDR_W   = 32;
   localparam int unsigned SA4_DATA_W   = 32;
   localparam int unsigned SA4_INDEX_W  = 8;
   localparam int unsigned SA4_OFFSET_W = 2;
   localparam int unsigned SA4_WAYS     = 4;
endpackage

// File: rtl/sa4_tag_cmp.sv
module sa4_tag_cmp #(
   parameter int unsigned TAG_W      = 22,
   parameter bit          XOR_REDUCE = 1'b1
) (
   input  logic [TAG_W-1:0] a,
   input  logic [TAG_W-1:0] b,
   output logic             eq
);
   generate
      if (XOR_REDUCE) begin : g_xor
         logic [TAG_W-1:0] diff;
         assign diff = a ^ b;
         assign eq   = ~|diff;
      end else begin : g_eq
         assign eq = (a == b);
      end
   endgenerate
endmodule

// File: rtl/sa4_way_store.sv
module sa4_way_store #(
   parameter int unsigned INDEX_W = 8,
   parameter int unsigned TAG_W   = 22,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] index,
   input  logic [TAG_W-1:0]   tag,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               way_hit,
   output logic [DATA_W-1:0]  way_data
);
   localparam int unsigned SETS = 1 << INDEX_W;

   logic [SETS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_mem  [SETS];
   logic [DATA_W-1:0] data_mem [SETS];
   logic              tag_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[index] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[index]  <= tag;
         data_mem[index] <= wr_data;
      end
   end

   sa4_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
      .a  (tag_mem[index]),
      .b  (tag),
      .eq (tag_eq)
   );

   assign way_hit  = valid_q[index] & tag_eq;
   assign way_data = data_mem[index];
endmodule

// File: rtl/sa4_hit_mux.sv
module sa4_hit_mux #(
   parameter int unsigned WAYS         = 4,
   parameter int unsigned DATA_W       = 32,
   parameter bit          ZERO_ON_MISS = 1'b1,
   localparam int unsigned WAY_W       = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]        hits,
   input  logic [WAYS*DATA_W-1:0] words,
   output logic                   any_hit,
   output logic [WAY_W-1:0]       sel,
   output logic [DATA_W-1:0]      word_out
);
   logic [DATA_W-1:0] picked;

   always_comb begin
      sel = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (hits[i]) sel = WAY_W'(i);
      end
   end

   assign any_hit = |hits;
   assign picked  = words[sel*DATA_W +: DATA_W];

   generate
      if (ZERO_ON_MISS) begin : g_zero
         assign word_out = any_hit ? picked : '0;
      end else begin : g_pass
         assign word_out = picked;
      end
   endgenerate
endmodule

// File: rtl/sa4_lookup.sv
module sa4_lookup #(
   parameter int unsigned ADDR_W   = sa4_pkg::SA4_ADDR_W,
   parameter int unsigned DATA_W   = sa4_pkg::SA4_DATA_W,
   parameter int unsigned INDEX_W  = sa4_pkg::SA4_INDEX_W,
   parameter int unsigned OFFSET_W = sa4_pkg::SA4_OFFSET_W,
   parameter int unsigned WAYS     = sa4_pkg::SA4_WAYS,
   localparam int unsigned TAG_W   = ADDR_W - INDEX_W - OFFSET_W,
   localparam int unsigned WAY_W   = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hit,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (ADDR_W <= INDEX_W + OFFSET_W) begin : g_bad_addr
         $error("sa4_lookup: address too narrow for index and offset");
      end
      if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("sa4_lookup: WAYS must be a power of two of at least 2");
      end
      if (OFFSET_W < 1) begin : g_bad_off
         $error("sa4_lookup: OFFSET_W must be at least 1");
      end
   endgenerate

   logic [TAG_W-1:0]       req_tag;
   logic [INDEX_W-1:0]     req_index;
   logic                   offset_unused;
   logic [WAYS-1:0]        way_hits;
   logic [WAYS*DATA_W-1:0] way_words;
   logic [WAY_W-1:0]       hit_sel;

   assign req_tag       = addr[ADDR_W-1 -: TAG_W];
   assign req_index     = addr[OFFSET_W +: INDEX_W];
   assign offset_unused = ^addr[OFFSET_W-1:0];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic way_we;
      assign way_we = wr_en & (wr_way == WAY_W'(w));

      sa4_way_store #(
         .INDEX_W (INDEX_W),
         .TAG_W   (TAG_W),
         .DATA_W  (DATA_W)
      ) u_store (
         .clk      (clk),
         .rst_n    (rst_n),
         .index    (req_index),
         .tag      (req_tag),
         .wr_en    (way_we),
         .wr_data  (wr_data),
         .way_hit  (way_hits[w]),
         .way_data (way_words[w*DATA_W +: DATA_W])
      );
   end

   sa4_hit_mux #(
      .WAYS   (WAYS),
      .DATA_W (DATA_W)
   ) u_mux (
      .hits     (way_hits),
      .words    (way_words),
      .any_hit  (hit),
      .sel      (hit_sel),
      .word_out (rd_data)
   );
endmodule

// File: rtl/sa4_lookup_chk.sv
module sa4_lookup_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WAY_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [WAY_W-1:0]  wr_way,
   input logic              hit,
   input logic [DATA_W-1:0] rd_data
);
   p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !hit);

   p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (rd_data == '0));

   p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ($stable(addr) |-> hit));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(addr) |-> ($stable(hit) && $stable(rd_data))));

   p_way_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$isunknown(wr_way));
endmodule

bind sa4_lookup sa4_lookup_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .WAY_W  (WAY_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wr_en   (wr_en),
   .wr_way  (wr_way),
   .hit     (hit),
   .rd_data (rd_data)
);

// File: tb/sa4_lookup_tb.sv
module sa4_lookup_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_way = '0;
   logic [31:0] wr_data = '0;
   logic        hit;
   logic [31:0] rd_data;

   int tests = 0;
   int fails = 0;

   logic [255:0] m_valid [4];
   logic [21:0]  m_tag   [4][256];
   logic [31:0]  m_data  [4][256];

   always #5 clk = ~clk;

   sa4_lookup u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_way  (wr_way),
      .wr_data (wr_data),
      .hit     (hit),
      .rd_data (rd_data)
   );

   function automatic logic [31:0] mk_addr(logic [21:0] t, logic [7:0] idx, logic [1:0] off);
      return {t, idx, off};
   endfunction

   function automatic logic [21:0] fill_tag(int idx, int w);
      return {w[1:0], idx[7:0], 12'h35A};
   endfunction

   function automatic logic [31:0] fill_word(int idx, int w);
      return {idx[7:0], w[7:0], 16'hBEEF ^ 16'(idx * 7)};
   endfunction

   task automatic do_write(int w, logic [21:0] t, int idx, logic [31:0] d);
      @(negedge clk);
      addr    = mk_addr(t, idx[7:0], 2'b00);
      wr_way  = w[1:0];
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      m_valid[w][idx] = 1'b1;
      m_tag[w][idx]   = t;
      m_data[w][idx]  = d;
   endtask

   task automatic probe(logic [21:0] t, int idx, logic [1:0] off, string req);
      logic        e_hit;
      logic [31:0] e_data;
      e_hit  = 1'b0;
      e_data = '0;
      for (int w = 3; w >= 0; w--) begin
         if (m_valid[w][idx] && m_tag[w][idx] == t) begin
            e_hit  = 1'b1;
            e_data = m_data[w][idx];
         end
      end
      @(negedge clk);
      addr = mk_addr(t, idx[7:0], off);
      #1;
      tests++;
      if (hit !== e_hit || rd_data !== e_data) begin
         fails++;
         $display("FAIL %s idx=%0d tag=%h: hit=%b data=%h expected hit=%b data=%h",
                  req, idx, t, hit, rd_data, e_hit, e_data);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int w = 0; w < 4; w++) m_valid[w] = '0;

      // R1: empty while in reset and right after release
      repeat (2) @(posedge clk);
      for (int i = 0; i < 256; i += 17) probe(fill_tag(i, 1), i, 2'(i), "R1");
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 256; i++) probe(fill_tag(i, i % 4), i, 2'(i), "R1");

      // R3: fill every set with four distinct tags
      for (int i = 0; i < 256; i++) begin
         for (int w = 0; w < 4; w++) begin
            do_write(w, fill_tag(i, w), i, fill_word(i, w));
         end
      end

      // R2 R4 R5: every tag under every byte offset
      for (int i = 0; i < 256; i++) begin
         for (int w = 0; w < 4; w++) begin
            for (int o = 0; o < 4; o++) probe(fill_tag(i, w), i, 2'(o), "R2_R4_R5");
         end
      end

      // R7: absent tags miss and read zero
      for (int i = 0; i < 256; i += 3) probe({2'b00, i[7:0], 12'h000}, i, 2'b11, "R7");

      // R9: tags of a neighbouring set do not hit
      for (int i = 0; i < 255; i += 5) probe(fill_tag(i + 1, 2), i, 2'b00, "R9");

      // R8: idle cycles with busy write lines change nothing
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         addr    = mk_addr(22'h3FFFFF, 8'(40 + k), 2'b00);
         wr_way  = k[1:0];
         wr_data = 32'hDEAD_0000 + k;
         wr_en   = 1'b0;
         @(negedge clk);
         probe(22'h3FFFFF, 40 + k, 2'b00, "R8");
         for (int w = 0; w < 4; w++) probe(fill_tag(40 + k, w), 40 + k, 2'b01, "R8");
      end

      // R6: duplicated tag, lowest way wins
      do_write(3, fill_tag(5, 1), 5, 32'h3333_3333);
      probe(fill_tag(5, 1), 5, 2'b00, "R6");
      do_write(0, fill_tag(5, 1), 5, 32'h0000_AAAA);
      probe(fill_tag(5, 1), 5, 2'b10, "R6");
      do_write(2, fill_tag(5, 1), 5, 32'h2222_2222);
      probe(fill_tag(5, 1), 5, 2'b01, "R6");

      // R10: overwritten tags no longer hit
      probe(fill_tag(5, 0), 5, 2'b00, "R10");
      probe(fill_tag(5, 3), 5, 2'b00, "R10");
      probe(fill_tag(5, 2), 5, 2'b00, "R10");
      do_write(1, 22'h1ABCDE, 9, 32'h1234_5678);
      probe(fill_tag(9, 1), 9, 2'b00, "R10");
      probe(22'h1ABCDE, 9, 2'b11, "R10");
      probe(22'h1ABCDE, 10, 2'b11, "R9");

      // R1: reset again clears all valid bits
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_valid[0] = '0; m_valid[1] = '0; m_valid[2] = '0; m_valid[3] = '0;
      for (int i = 0; i < 256; i += 11) probe(fill_tag(i, 3), i, 2'b00, "R1");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule